// File: doc/BRIEF.md
# Mode-Controlled Six-Pin Input Port

This block is a general-purpose input port for six pins. A control register holds a 2-bit mode for each pin. The mode decides whether the pin is a plain input with its pull-up on, a plain input with its pull-up off, or handed over to an alternate function. A read-only data register returns the synchronized level of every pin that is in an input mode. Pins that are not in an input mode read as zero. The block drives one pull-up enable per pin straight from the mode.

Software reaches the port through a simple register interface with an address, a read strobe, a write strobe and a 16-bit data bus. The control register is at offset 0 and the data register is at offset 2. Read data is registered and appears one cycle after the read strobe. Two resets are supported. The power-on reset restores every pin to input with the pull-up on. The manual reset leaves the modes and the synchronizers untouched and only clears the bus read-data register.

Top module: `modeport_top`

## Requirements
- R1: While `por_n` is low at a clock edge, every mode resets to 2'b10. After that edge all `pullup_en` bits are 1 and `rdata` is 0.
- R2: A data-register read (address 2) returns, in bit n, the synchronized level of pin n when the mode of pin n is 2'b10 or 2'b11.
- R3: A data-register read returns 0 in bit n when the mode of pin n is 2'b00 (alternate function) or 2'b01 (reserved).
- R4: `pullup_en[n]` is 1 exactly when the mode of pin n is 2'b10. It follows a control write in the cycle after the write edge.
- R5: A data-register read returns 0 in bits 15 to 6.
- R6: A write to the data register changes no mode, no pull-up enable and no later read value.
- R7: While `mrst_n` is low, `rdata` is cleared at each edge. Modes, pull-ups and synchronizer contents are kept and keep running.
- R8: Each pin passes through two flops. A read issued in the cycle of edge k returns the pin level sampled at edge k-2.
- R9: A control-register read (address 0) returns the mode of pin n in bits 2n+1:2n and 0 in bits 15 to 12. A control write loads those same fields from `wdata`.
- R10: `rdata` is updated one cycle after `rd_en` and holds its value while no read is issued.
- R11: A read of any address other than 0 or 2 returns 0. A write to such an address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low; clears only read data |
| addr | input | 4 | Register address (0 = control, 2 = data) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 6 | Pin levels, asynchronous to `clk` |
| pullup_en | output | 6 | Pull-up enable per pin |

## Verification
The assertions assume a few things about the bus. Both resets are sampled synchronously. The bus strobes are never unknown after power-on reset. The address is stable during a strobe cycle. The stimulus meets these conditions by changing all inputs only on the falling clock edge. It holds power-on reset low from time zero for several edges, and it keeps every strobe a clean single-cycle or multi-cycle pulse. Pin changes are placed on the falling edge too, so the two-flop latency seen by the model is exact rather than metastable.

// File: rtl/modeport_pkg.sv
// Package: shared constants, mode encoding and helpers for the six-pin input port.
// Assumes a register bus with a word-granular address; offsets are in address units.
package modeport_pkg;

    localparam int NUM_PINS_DEF = 6;
    localparam int DATA_W_DEF   = 16;
    localparam int ADDR_W_DEF   = 4;
    localparam int SYNC_DEF     = 2;
    localparam int CTRL_OFF     = 0;
    localparam int DATA_OFF     = 2;

    typedef enum logic [1:0] {
        MODE_ALT     = 2'b00,
        MODE_RSVD    = 2'b01,
        MODE_IN_PU   = 2'b10,
        MODE_IN_NOPU = 2'b11
    } pin_mode_e;

    // True when the mode passes the pin level through to the data register.
    function automatic logic mode_is_input(input logic [1:0] m);
        return (m == MODE_IN_PU) || (m == MODE_IN_NOPU);
    endfunction

    // True when the mode asks for the pull-up device.
    function automatic logic mode_wants_pullup(input logic [1:0] m);
        return m == MODE_IN_PU;
    endfunction

endpackage

// File: rtl/modeport_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no multi-bit coherence is promised.
// The stages are cleared only by power-on reset.
module modeport_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pin levels.
    always_ff @(posedge clk) begin
        if (!por_n) stg[0] <= '0;
        else        stg[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!por_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/modeport_ctrl.sv
// Module: per-pin mode register with its write decode.
// Assumes wr_en is a single-cycle strobe with addr valid alongside it.
// Only power-on reset reloads the modes; the manual reset is not seen here.
module modeport_ctrl
    import modeport_pkg::*;
#(
    parameter int NUM_PINS = NUM_PINS_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*NUM_PINS-1:0] mode_vec
);

    localparam int CTRL_W = 2 * NUM_PINS;

    logic ctrl_hit;
    logic [CTRL_W-1:0] reset_val;

    // Address match for the control register.
    assign ctrl_hit = wr_en && (addr == ADDR_W'(CTRL_OFF));

    // Every pin's reset mode is input with pull-up on.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            reset_val[2*p +: 2] = MODE_IN_PU;
        end
    end

    // Hold or load the mode fields.
    always_ff @(posedge clk) begin
        if (!por_n)        mode_vec <= reset_val;
        else if (ctrl_hit) mode_vec <= wdata[CTRL_W-1:0];
    end

endmodule

// File: rtl/modeport_pin.sv
// Module: decode of one pin's mode into its pull-up enable and gated read bit.
// Assumes level is already synchronized to the bus clock.
module modeport_pin
    import modeport_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       level,
    output logic       pull_up,
    output logic       rd_bit
);

    // Pull-up follows the input-with-pull-up mode only.
    assign pull_up = mode_wants_pullup(mode);

    // Alternate and reserved modes read as zero.
    assign rd_bit = mode_is_input(mode) & level;

endmodule

// File: rtl/modeport_rdmux.sv
// Module: registered read multiplexer for the control and data registers.
// Assumes rd_en is valid on the same cycle as addr. Either reset clears the
// output register; unmapped addresses return zero.
module modeport_rdmux
    import modeport_pkg::*;
#(
    parameter int NUM_PINS = NUM_PINS_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  mrst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*NUM_PINS-1:0] mode_vec,
    input  logic [NUM_PINS-1:0]   data_bits,
    output logic [DATA_W-1:0]     rdata
);

    localparam int CTRL_W = 2 * NUM_PINS;

    logic [DATA_W-1:0] rd_next;

    // Select the word for the addressed register, zero-extended.
    always_comb begin
        rd_next = '0;
        if (addr == ADDR_W'(CTRL_OFF))      rd_next[CTRL_W-1:0]   = mode_vec;
        else if (addr == ADDR_W'(DATA_OFF)) rd_next[NUM_PINS-1:0] = data_bits;
    end

    // Capture on a read strobe, clear on either reset, else hold.
    always_ff @(posedge clk) begin
        if (!por_n || !mrst_n) rdata <= '0;
        else if (rd_en)        rdata <= rd_next;
    end

endmodule

// File: rtl/modeport_top.sv
// Module: six-pin input-only port with per-pin mode control.
// Assumes pin_in is asynchronous and both resets are synchronous, active low.
// The data register is read-only; writes to it are dropped by the decode.
module modeport_top
    import modeport_pkg::*;
#(
    parameter int NUM_PINS    = NUM_PINS_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                mrst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pullup_en
);

    localparam int CTRL_W = 2 * NUM_PINS;

    logic [CTRL_W-1:0]   mode_vec;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] data_bits;

    modeport_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    modeport_ctrl #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .por_n    (por_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .mode_vec (mode_vec)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            modeport_pin u_pin (
                .mode    (mode_vec[2*p +: 2]),
                .level   (pin_sync[p]),
                .pull_up (pullup_en[p]),
                .rd_bit  (data_bits[p])
            );
        end
    endgenerate

    modeport_rdmux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .clk       (clk),
        .por_n     (por_n),
        .mrst_n    (mrst_n),
        .rd_en     (rd_en),
        .addr      (addr),
        .mode_vec  (mode_vec),
        .data_bits (data_bits),
        .rdata     (rdata)
    );

endmodule

// File: rtl/modeport_chk.sv
// Module: property checker for modeport_top, attached through bind.
// Assumes inputs change away from the clock edge and por_n starts low.
module modeport_chk
    import modeport_pkg::*;
#(
    parameter int NUM_PINS = NUM_PINS_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF
) (
    input logic                  clk,
    input logic                  por_n,
    input logic                  mrst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic [DATA_W-1:0]     rdata,
    input logic [NUM_PINS-1:0]   pullup_en,
    input logic [2*NUM_PINS-1:0] mode_vec
);

    logic [NUM_PINS-1:0] off_mask;
    logic                data_rd;

    // Pins whose mode is not an input mode.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) off_mask[p] = ~mode_vec[2*p+1];
    end

    assign data_rd = rd_en && mrst_n && (addr == ADDR_W'(DATA_OFF));

    // R1: leaving power-on reset, every pull-up is on.
    p_por_pullup_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (pullup_en == '1));

    // R3: non-input pins read as zero.
    p_off_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
        data_rd |=> ((rdata[NUM_PINS-1:0] & $past(off_mask)) == '0));

    // R5: reserved upper data bits read as zero.
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
        data_rd |=> (rdata[DATA_W-1:NUM_PINS] == '0));

    // R6: a write elsewhere than the control register leaves pull-ups alone.
    p_dwrite_ignored_r6: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && addr != ADDR_W'(CTRL_OFF)) |=> $stable(pullup_en));

    // R7: manual reset clears read data.
    p_mrst_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> (rdata == '0));

    // R7: manual reset alone does not disturb pull-ups.
    p_mrst_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !wr_en) |=> $stable(pullup_en));

    // R10: read data holds without a read strobe.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_en && mrst_n) |=> $stable(rdata));

endmodule

bind modeport_top modeport_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .pullup_en (pullup_en),
    .mode_vec  (mode_vec)
);

// File: tb/modeport_top_tb.sv
`timescale 1ns/1ps
module modeport_top_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic [3:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [5:0]  pin_in = '0;
    logic [5:0]  pullup_en;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string cur_req = "R1";

    // Reference model state
    int          mode_m [6];
    logic [5:0]  hist [$];
    logic [15:0] rd_m = '0;

    always #4 clk = ~clk;

    modeport_top u_dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .pin_in(pin_in), .pullup_en(pullup_en)
    );

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        logic [15:0] nx;
        cycles++;
        if (!por_n) begin
            for (int i = 0; i < 6; i++) mode_m[i] = 2;
            hist = {6'h00, 6'h00};
            rd_m = '0;
        end else begin
            nx = rd_m;
            if (!mrst_n) nx = '0;
            else if (rd_en) begin
                nx = '0;
                if (addr == 4'd0)
                    for (int i = 0; i < 6; i++) nx[2*i +: 2] = 2'(mode_m[i]);
                else if (addr == 4'd2)
                    for (int i = 0; i < 6; i++) if (mode_m[i] >= 2) nx[i] = hist[1][i];
            end
            if (wr_en && addr == 4'd0)
                for (int i = 0; i < 6; i++) mode_m[i] = int'(wdata[2*i +: 2]);
            hist.push_front(pin_in);
            void'(hist.pop_back());
            rd_m = nx;
        end
    end

    // Compare the ports against the model after every edge.
    always @(posedge clk) begin
        logic [5:0] pu_m;
        #2;
        if (cycles > 1) begin
            for (int i = 0; i < 6; i++) pu_m[i] = (mode_m[i] == 2);
            vectors++;
            if (rdata !== rd_m) begin
                errors++;
                $display("FAIL %s rdata actual %h expected %h at cycle %0d", cur_req, rdata, rd_m, cycles);
            end
            vectors++;
            if (pullup_en !== pu_m) begin
                errors++;
                $display("FAIL %s pullup_en actual %b expected %b at cycle %0d", cur_req, pullup_en, pu_m, cycles);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [5:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: power-on reset defaults
        cur_req = "R1";
        idle(3);
        @(negedge clk); por_n = 1'b1;
        idle(2);

        // R2: default mode passes pin levels
        cur_req = "R2";
        set_pins(6'h2D); idle(3); bus_rd(4'd2); idle(2);
        set_pins(6'h12); idle(3); bus_rd(4'd2); idle(2);

        // R9 and R4: mixed modes, control readback, pull-up pattern
        cur_req = "R9";
        bus_wr(4'd0, 16'hFBE4); idle(1); bus_rd(4'd0); idle(1);
        cur_req = "R4";
        idle(2);

        // R3 and R5: alternate/reserved pins read zero, upper bits zero
        cur_req = "R3";
        set_pins(6'h3F); idle(3); bus_rd(4'd2); idle(1);
        cur_req = "R5";
        bus_rd(4'd2); idle(1);

        // R6: data-register writes ignored
        cur_req = "R6";
        bus_wr(4'd2, 16'hFFFF); bus_wr(4'd2, 16'h0000);
        bus_rd(4'd0); bus_rd(4'd2); idle(1);

        // R11: unmapped address
        cur_req = "R11";
        bus_wr(4'd15, 16'h0000); bus_rd(4'd15); idle(1); bus_rd(4'd0); idle(1);

        // R7: manual reset holds modes and keeps synchronizing
        cur_req = "R7";
        @(negedge clk); mrst_n = 1'b0; pin_in = 6'h0A; rd_en = 1'b1; addr = 4'd2;
        idle(3);
        @(negedge clk); mrst_n = 1'b1; rd_en = 1'b0;
        bus_rd(4'd0); bus_rd(4'd2); idle(1);

        // R8: two-flop latency on pin changes
        cur_req = "R8";
        bus_wr(4'd0, 16'h0FFF); set_pins(6'h00); idle(3);
        @(negedge clk); pin_in = 6'h3F; addr = 4'd2; rd_en = 1'b1;
        idle(4);
        @(negedge clk); rd_en = 1'b0; pin_in = 6'h15;
        idle(1);

        // R10: rdata holds between reads
        cur_req = "R10";
        idle(4);

        // R1: a second power-on reset restores defaults
        cur_req = "R1";
        @(negedge clk); por_n = 1'b0;
        idle(2);
        @(negedge clk); por_n = 1'b1;
        idle(3); bus_rd(4'd0); idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule